// File: doc/BRIEF.md
# Scrambling NRZI Word Serializer

This block turns parallel words into a single serial bit line, one bit each time a bit-rate enable is high. It runs from one fast clock. `bit_en` stands in for a clock ten times faster than the word rate, so every word gives exactly `WORD_W` serial bits. Each bit goes through a self-synchronising scrambler with polynomial x^9 + x^4 + 1. The scrambled bit then drives an x + 1 NRZI stage, which toggles the line on every scrambled one. The result leaves on a registered true/complement output pair.

Three controls shape the stream:
- A bypass input sends the raw serial bits straight to the line, with neither coding stage.
- A clear input empties the scrambler history.
- A lock input mutes the output while low, for example while an upstream clock is not yet stable.

The `word_take` output flags the enable on which `word_in` is captured. This lets a word source change its data at the word rate with no gap between words.

Top module: `vid_scramble_serializer`

## Requirements
- R1: `word_take` is high during the enable that captures `word_in`. It is high once every `WORD_W` (10) bit enables, with no idle enable between words. After reset, the first enable captures a word.
- R2: Each word is sent least significant bit first: bit 0 in the capture enable, then bits 1 through 9 in the next nine enables.
- R3: With bypass low, the scrambled bit is s = d XOR h[8] XOR h[3], where h[0] is the scrambled bit of the previous enable. On each enable the history shifts as h <= {h[7:0], s}.
- R4: With bypass low and lock high, the line level after an enable is the previous NRZI level XOR s. The line toggles on a scrambled 1 and holds on a scrambled 0.
- R5: With bypass high, the line after an enable equals the raw serial bit d. Neither the scrambler history nor the NRZI level changes on that enable.
- R6: `scr_clear` high at a clock edge sets all nine history bits to 0. This wins over any shift on the same edge. The scrambled bit of that enable still uses the old history.
- R7: While `locked` is low, `sd_p` is 0 and `sd_n` is 1. The NRZI level does not change on any enable, and the scrambler keeps running. With bypass low, the line register then reloads the held NRZI level.
- R8: `sd_n` is always the complement of `sd_p`.
- R9: After reset, the scrambler history and the NRZI level are 0, the line register is 0 and `word_take` is high.
- R10: The line register changes only at clock edges where `bit_en` is high. Between enables the output holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, at least the serial bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Serial bit-rate enable |
| word_in | input | WORD_W | Parallel word, captured when `word_take` and `bit_en` are high |
| word_take | output | 1 | High when the next enable captures `word_in` |
| bypass | input | 1 | Sends raw serial bits, skipping scrambler and NRZI |
| scr_clear | input | 1 | Synchronous clear of the scrambler history |
| locked | input | 1 | Output is muted while low |
| sd_p | output | 1 | Serial data, true |
| sd_n | output | 1 | Serial data, complement |

## Verification
The embedded properties check the following on every cycle:
- the bit counter's wrap,
- the history shift, hold and clear,
- the NRZI hold while muted or bypassed,
- the line following the NRZI level or the raw bit,
- the line holding between enables.

The actual scrambled values, the LSB-first order and the word cadence under sparse enables can only be shown by the bench's scenarios. Those scenarios compare the line against a behavioural model on every clock, across runs with bypass on and off, clear pulses and lock toggling.

// File: rtl/vid_ser_pkg.sv
package vid_ser_pkg;
   localparam int unsigned WORD_W_DEF  = 10;
   localparam int unsigned HIST_LEN_DEF = 9;
   localparam int unsigned HIST_TAP_DEF = 4;

   typedef enum logic [1:0] {
      LINE_RAW  = 2'd0,
      LINE_CODE = 2'd1,
      LINE_HELD = 2'd2
   } line_src_e;
endpackage

// File: rtl/vid_word_shifter.sv
module vid_word_shifter #(
   parameter int unsigned WORD_W    = 10,
   parameter bit          LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic [WORD_W-1:0] word_in,
   output logic              take,
   output logic              raw_bit
);
   localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

   generate
      if (WORD_W < 2) begin : g_bad_width
         $error("vid_word_shifter: WORD_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0]  cnt_q;
   logic [WORD_W-1:0] sh_q;
   logic [WORD_W-1:0] sh_next;

   assign take = (cnt_q == LAST);

   generate
      if (LSB_FIRST) begin : g_lsb
         assign raw_bit = take ? word_in[0] : sh_q[0];
         assign sh_next = take ? (word_in >> 1) : (sh_q >> 1);
      end else begin : g_msb
         assign raw_bit = take ? word_in[WORD_W-1] : sh_q[WORD_W-1];
         assign sh_next = take ? (word_in << 1) : (sh_q << 1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= LAST;
         sh_q  <= '0;
      end else if (bit_en) begin
         sh_q  <= sh_next;
         cnt_q <= take ? '0 : cnt_q + 1'b1;
      end
   end

   // R1
   cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && take) |=> (cnt_q == '0));
   // R1
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);
endmodule

// File: rtl/vid_self_sync_scrambler.sv
module vid_self_sync_scrambler #(
   parameter int unsigned LEN = 9,
   parameter int unsigned TAP = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic adv,
   input  logic clr,
   input  logic din,
   output logic dout
);
   generate
      if (LEN < 2 || TAP < 1 || TAP >= LEN) begin : g_bad_taps
         $error("vid_self_sync_scrambler: need 1 <= TAP < LEN");
      end
   endgenerate

   logic [LEN-1:0] hist_q;

   assign dout = din ^ hist_q[LEN-1] ^ hist_q[TAP-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= '0;
      end else if (clr) begin
         hist_q <= '0;
      end else if (adv) begin
         hist_q <= {hist_q[LEN-2:0], dout};
      end
   end

   // R6
   hist_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (hist_q == '0));
   // R3
   hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !clr) |=> (hist_q[LEN-1:1] == $past(hist_q[LEN-2:0])));
   // R5
   hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !clr) |=> $stable(hist_q));
endmodule

// File: rtl/vid_nrzi_encoder.sv
module vid_nrzi_encoder (
   input  logic clk,
   input  logic rst_n,
   input  logic adv,
   input  logic din,
   output logic level,
   output logic level_next
);
   assign level_next = level ^ din;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   level <= 1'b0;
      else if (adv) level <= level_next;
   end

   // R7
   level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(level));
endmodule

// File: rtl/vid_scramble_serializer.sv
module vid_scramble_serializer
   import vid_ser_pkg::*;
#(
   parameter int unsigned WORD_W    = WORD_W_DEF,
   parameter int unsigned HIST_LEN  = HIST_LEN_DEF,
   parameter int unsigned HIST_TAP  = HIST_TAP_DEF,
   parameter bit          LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic [WORD_W-1:0] word_in,
   output logic              word_take,
   input  logic              bypass,
   input  logic              scr_clear,
   input  logic              locked,
   output logic              sd_p,
   output logic              sd_n
);
   logic      raw_bit;
   logic      scr_bit;
   logic      nrzi_level;
   logic      nrzi_next;
   logic      line_q;
   logic      line_d;
   line_src_e line_src;

   vid_word_shifter #(.WORD_W(WORD_W), .LSB_FIRST(LSB_FIRST)) shifter_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .bit_en  (bit_en),
      .word_in (word_in),
      .take    (word_take),
      .raw_bit (raw_bit)
   );

   vid_self_sync_scrambler #(.LEN(HIST_LEN), .TAP(HIST_TAP)) scrambler_i (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (bit_en & ~bypass),
      .clr   (scr_clear),
      .din   (raw_bit),
      .dout  (scr_bit)
   );

   vid_nrzi_encoder nrzi_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .adv        (bit_en & ~bypass & locked),
      .din        (scr_bit),
      .level      (nrzi_level),
      .level_next (nrzi_next)
   );

   always_comb begin
      if (bypass)      line_src = LINE_RAW;
      else if (locked) line_src = LINE_CODE;
      else             line_src = LINE_HELD;
      unique case (line_src)
         LINE_RAW:  line_d = raw_bit;
         LINE_CODE: line_d = nrzi_next;
         default:   line_d = nrzi_level;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       line_q <= 1'b0;
      else if (bit_en)  line_q <= line_d;
   end

   assign sd_p = locked & line_q;
   assign sd_n = ~sd_p;

   // R4
   line_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && locked && !bypass) |=> (line_q == nrzi_level));
   // R5
   bypass_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && bypass) |=> (line_q == $past(raw_bit)));
   // R10
   line_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(line_q));
endmodule

// File: tb/vid_scramble_serializer_tb.sv
module vid_scramble_serializer_tb_top;
   localparam time CLK_PERIOD = 10ns;
   localparam int  WW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bit_en = 1'b0;
   logic [WW-1:0] word_in = '0;
   logic          bypass = 1'b0;
   logic          scr_clear = 1'b0;
   logic          locked = 1'b0;
   logic          word_take, sd_p, sd_n;

   int n_chk = 0;
   int n_fail = 0;

   int          m_cnt;
   logic [9:0]  m_sh;
   logic [8:0]  m_h;
   logic        m_nrzi, m_line;

   always #(CLK_PERIOD/2) clk = ~clk;

   vid_scramble_serializer dut_i (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .word_in(word_in),
      .word_take(word_take), .bypass(bypass), .scr_clear(scr_clear),
      .locked(locked), .sd_p(sd_p), .sd_n(sd_n)
   );

   task automatic chk(input logic act, input logic exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   // One clock: drive at the negative edge, advance the model, compare after the edge.
   task automatic step(input logic be, input logic byp, input logic lk,
                       input logic clr, input logic [WW-1:0] w, input string tag);
      logic d, s, nz;
      bit_en = be; bypass = byp; locked = lk; scr_clear = clr; word_in = w;
      if (be) begin
         d = (m_cnt == 9) ? w[0] : m_sh[0];
         if (m_cnt == 9) begin m_sh = w >> 1; m_cnt = 0; end
         else begin m_sh = m_sh >> 1; m_cnt++; end
         s  = d ^ m_h[8] ^ m_h[3];
         nz = m_nrzi ^ s;
         if (byp)     m_line = d;
         else if (lk) m_line = nz;
         else         m_line = m_nrzi;
         if (!byp && lk) m_nrzi = nz;
         if (!byp)       m_h = {m_h[7:0], s};
      end
      if (clr) m_h = '0;
      @(posedge clk);
      @(negedge clk);
      chk(sd_p, lk ? m_line : 1'b0, be ? tag : "R10");
      chk(sd_n, ~(lk ? m_line : 1'b0), "R8");
      chk(word_take, m_cnt == 9, "R1");
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [WW-1:0] pat [4];
      pat[0] = 10'h001; pat[1] = 10'h2AA; pat[2] = 10'h3FF; pat[3] = 10'h000;
      m_cnt = 9; m_sh = '0; m_h = '0; m_nrzi = 1'b0; m_line = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      locked = 1'b1;
      @(negedge clk);
      // R9: reset state
      chk(sd_p, 1'b0, "R9");
      chk(word_take, 1'b1, "R9");
      // R2 R5: raw LSB-first words in bypass
      for (int i = 0; i < 40; i++) step(1, 1, 1, 0, pat[i/10], "R2 R5");
      // R6: clear from zero history, then zero data keeps the line flat
      step(1, 0, 1, 1, '0, "R6");
      for (int i = 0; i < 19; i++) step(1, 0, 1, 0, '0, "R6");
      // R3 R4: scrambled and NRZI coded words
      for (int i = 0; i < 200; i++) step(1, 0, 1, 0, WW'($urandom), "R3 R4");
      // R10: sparse enables
      for (int i = 0; i < 150; i++) step(i % 3 == 0, 0, 1, 0, WW'($urandom), "R10");
      // R6: clear pulses mid-stream
      for (int i = 0; i < 100; i++)
         step(1, 0, 1, ($urandom % 16) == 0, WW'($urandom), "R6");
      // R7: lock toggling
      for (int i = 0; i < 200; i++)
         step($urandom % 2, 0, (i / 17) % 2 == 0, 0, WW'($urandom), "R7");
      // R5: mixed bypass with everything else varying
      for (int i = 0; i < 300; i++)
         step($urandom % 4 != 0, (i / 23) % 2 == 1, ($urandom % 8) != 0,
              ($urandom % 32) == 0, WW'($urandom), "R5");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule